// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the engine of a single DMA channel. A descriptor is four 32-bit words: a device address, a memory address, a size word and a link word. The size word carries the element width and the element count. The link word carries two control bits and the word-aligned address of the following descriptor. For each descriptor the engine issues one mover request per element. The device address stays fixed for the whole descriptor. The memory address steps by the element width after each element. The configured direction decides which of the two addresses is the source.

Software first loads the first descriptor into the channel's registers, which arrive here as four input words. It then selects a mode and pulses start. In one-shot mode only that loaded descriptor is executed. In chained mode the engine reads each following descriptor through a request/grant memory port and continues until a descriptor ends the chain. A malformed descriptor stops the channel and reports an error. Writing the disabled mode aborts the channel at any point.

Top module: `dma_chain_seq`

## Requirements
- R1: In chained mode (mode 1), a descriptor whose link bit 1 is set makes the engine read four words. They are read from consecutive word addresses starting at the link word with bits [1:0] cleared, and loaded in the order device address, memory address, size, link. The engine then executes that descriptor.
- R2: Size bits [13:12] select the element width: 3 is 1 byte, 2 is 2 bytes, 0 is 4 bytes. Size bits [10:0] are the element count. Bit 11 is ignored. The width in bytes is presented on the mover size output.
- R3: Width code 1, or a count above 0x3FF for 1- or 2-byte width, or a count above 0x7FF for 4-byte width, is a descriptor error. No element is moved. The error and completion outputs pulse together for one cycle, and the channel returns to idle.
- R4: Link bit 0 set makes the completion output pulse for one cycle once the descriptor's last element is accepted. This also happens when the chain continues. Link bit 0 clear gives no pulse.
- R5: In one-shot mode (mode 2 or 3), only the descriptor loaded from the register inputs is executed. Link bit 1 is ignored and no memory read is issued.
- R6: Mode 0 returns the channel to idle on the next clock from any state. No completion or error pulse is produced.
- R7: Start is accepted only while the channel is idle and the mode is not 0. A start pulse or changed register inputs while busy have no effect on the running transfer.
- R8: The state output encodes 0 idle, 1 descriptor fetch, 2 waiting/decode, 3 transferring. After reset it reads idle with no request or event asserted.
- R9: Element k (from 0) of a descriptor uses memory address base + k·width and the unchanged device address. Direction 1 sends memory to device (source is the memory address). Direction 0 sends device to memory.
- R10: A descriptor with count 0 completes without any mover request and then follows its link bits like any other descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 0 disabled/abort, 1 chained, 2 or 3 one-shot |
| dir_to_dev_i | input | 1 | 1 memory to device, 0 device to memory |
| start_i | input | 1 | Start pulse, honoured only when idle |
| reg_dev_i | input | 32 | Loaded descriptor: device address |
| reg_mem_i | input | 32 | Loaded descriptor: memory address |
| reg_size_i | input | 32 | Loaded descriptor: size word |
| reg_link_i | input | 32 | Loaded descriptor: link word |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Descriptor word address |
| rd_gnt_i | input | 1 | Read granted; data valid in the same cycle |
| rd_data_i | input | 32 | Descriptor word read data |
| xfer_req_o | output | 1 | Element move request |
| xfer_src_o | output | 32 | Element source address |
| xfer_dst_o | output | 32 | Element destination address |
| xfer_bytes_o | output | 3 | Element width in bytes (1, 2 or 4) |
| xfer_ack_i | input | 1 | Element accepted |
| state_o | output | 2 | Channel state |
| done_o | output | 1 | Completion event, one-cycle pulse |
| err_o | output | 1 | Error event, one-cycle pulse |

## Verification
Start sampled at an edge puts the channel in decode at that edge. The first mover or read request then shows one edge later. Each accepted element or granted word moves the addresses or the word index by the next edge. The completion and error pulses rise at the same edge that returns the state to idle. An abort shows as idle one edge after mode 0 is applied. The bench drives every input and samples every output at the falling edge, half a cycle clear of the registers. Each element or word is acknowledged in the falling-edge slot where its request is seen. This makes every expected address line up with the element index that the bench counts.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } dcs_state_e;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_CHAIN = 2'd1;

  localparam int WORD_W   = 32;
  localparam int WORDS    = 4;
  localparam int IDX_W    = $clog2(WORDS);
  localparam int W_SLOT   = 1;
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcs_decode.sv
module dcs_decode #(
  parameter int          CNT_W      = 11,
  parameter int          WCODE_LSB  = 12,
  parameter logic [15:0] LIM_NARROW = 16'h03FF,
  parameter logic [15:0] LIM_WIDE   = 16'h07FF
) (
  input  logic [31:0]      size_word,
  output logic [2:0]       wbytes,
  output logic [CNT_W-1:0] count,
  output logic             bad
);
  localparam int LIM_W = 16;

  logic [1:0]       wcode;
  logic [LIM_W-1:0] limit;
  logic             code_bad;

  assign wcode = size_word[WCODE_LSB+1:WCODE_LSB];
  assign count = size_word[CNT_W-1:0];

  always_comb begin
    code_bad = 1'b0;
    wbytes   = 3'd4;
    limit    = LIM_WIDE;
    case (wcode)
      2'd3:    begin wbytes = 3'd1; limit = LIM_NARROW; end
      2'd2:    begin wbytes = 3'd2; limit = LIM_NARROW; end
      2'd0:    begin wbytes = 3'd4; limit = LIM_WIDE;   end
      default: begin wbytes = 3'd4; limit = LIM_WIDE; code_bad = 1'b1; end
    endcase
  end

  assign bad = code_bad | ({{(LIM_W-CNT_W){1'b0}}, count} > limit);
endmodule

// File: rtl/dcs_desc_regs.sv
module dcs_desc_regs
  import dcs_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_all,
  input  logic [WORDS-1:0][WORD_W-1:0] ld_words,
  input  logic                        fetch_we,
  input  logic [IDX_W-1:0]            fetch_idx,
  input  logic [WORD_W-1:0]           fetch_data,
  input  logic                        arm,
  input  logic [CNT_W-1:0]            arm_count,
  input  logic                        step,
  input  logic [2:0]                  step_bytes,
  output logic [WORDS-1:0][WORD_W-1:0] words_q,
  output logic [CNT_W-1:0]            remain_q
);
  logic [WORDS-1:0][WORD_W-1:0] words_d;
  logic [WORDS-1:0]             words_en;
  logic [CNT_W-1:0]             remain_d;
  logic                         remain_en;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_comb begin
      words_en[k] = 1'b0;
      words_d[k]  = words_q[k];
      if (ld_all) begin
        words_en[k] = 1'b1;
        words_d[k]  = ld_words[k];
      end else if (fetch_we && (fetch_idx == IDX_W'(k))) begin
        words_en[k] = 1'b1;
        words_d[k]  = fetch_data;
      end else if ((k == W_SLOT) && step) begin
        words_en[k] = 1'b1;
        words_d[k]  = words_q[k] + {{(WORD_W-3){1'b0}}, step_bytes};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           words_q[k] <= '0;
      else if (words_en[k]) words_q[k] <= words_d[k];
    end
  end

  always_comb begin
    remain_en = arm | step;
    remain_d  = arm ? arm_count : (remain_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        dir_to_dev_i,
  input  logic        start_i,
  input  logic [31:0] reg_dev_i,
  input  logic [31:0] reg_mem_i,
  input  logic [31:0] reg_size_i,
  input  logic [31:0] reg_link_i,
  output logic        rd_req_o,
  output logic [31:0] rd_addr_o,
  input  logic        rd_gnt_i,
  input  logic [31:0] rd_data_i,
  output logic        xfer_req_o,
  output logic [31:0] xfer_src_o,
  output logic [31:0] xfer_dst_o,
  output logic [2:0]  xfer_bytes_o,
  input  logic        xfer_ack_i,
  output logic [1:0]  state_o,
  output logic        done_o,
  output logic        err_o
);
  logic rs_n;

  dcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rs_n)
  );

  dcs_state_e                  state_q, state_d;
  logic [IDX_W-1:0]            idx_q, idx_d;
  logic                        done_q, done_d, err_q, err_d;
  logic                        ld_all, fetch_we, arm, step;
  logic [WORDS-1:0][WORD_W-1:0] ld_words, words_q;
  logic [CNT_W-1:0]            remain_q, count;
  logic [2:0]                  wbytes;
  logic                        bad;
  logic [31:0]                 dev_q, mem_q, size_q, link_q;
  logic                        link_follow, link_irq, run_off;

  assign ld_words = {reg_link_i, reg_size_i, reg_mem_i, reg_dev_i};
  assign dev_q    = words_q[0];
  assign mem_q    = words_q[1];
  assign size_q   = words_q[2];
  assign link_q   = words_q[3];

  dcs_desc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rs_n),
    .ld_all(ld_all), .ld_words(ld_words),
    .fetch_we(fetch_we), .fetch_idx(idx_q), .fetch_data(rd_data_i),
    .arm(arm), .arm_count(count),
    .step(step), .step_bytes(wbytes),
    .words_q(words_q), .remain_q(remain_q)
  );

  dcs_decode #(.CNT_W(CNT_W)) u_dec (
    .size_word(size_q), .wbytes(wbytes), .count(count), .bad(bad)
  );

  assign run_off     = (mode_i == MODE_OFF);
  assign link_follow = link_q[1] && (mode_i == MODE_CHAIN);
  assign link_irq    = link_q[0];

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    ld_all   = 1'b0;
    fetch_we = 1'b0;
    arm      = 1'b0;
    step     = 1'b0;
    if (run_off) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ld_all  = 1'b1;
            state_d = ST_WAIT;
          end
        end
        ST_FETCH: begin
          if (rd_gnt_i) begin
            fetch_we = 1'b1;
            idx_d    = idx_q + 1'b1;
            if (idx_q == IDX_W'(WORDS-1)) state_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bad) begin
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (count == '0) begin
            done_d  = link_irq;
            idx_d   = '0;
            state_d = link_follow ? ST_FETCH : ST_IDLE;
          end else begin
            arm     = 1'b1;
            state_d = ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (xfer_ack_i) begin
            step = 1'b1;
            if (remain_q == CNT_W'(1)) begin
              done_d  = link_irq;
              idx_d   = '0;
              state_d = link_follow ? ST_FETCH : ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign state_o      = state_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign rd_req_o     = (state_q == ST_FETCH);
  assign rd_addr_o    = {link_q[31:2], 2'b00} + {{(30-IDX_W){1'b0}}, idx_q, 2'b00};
  assign xfer_req_o   = (state_q == ST_MOVE);
  assign xfer_src_o   = dir_to_dev_i ? mem_q : dev_q;
  assign xfer_dst_o   = dir_to_dev_i ? dev_q : mem_q;
  assign xfer_bytes_o = wbytes;

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rs_n)
    (mode_i == MODE_OFF) |=> (state_o == 2'd0) && !done_o && !err_o); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rs_n)
    err_o |-> (done_o && state_o == 2'd0)); // R3

  AST_MOVE_NONZERO: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q == ST_MOVE) |-> (remain_q != '0)); // R10

  AST_DEV_HELD: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q == ST_MOVE && xfer_ack_i && !run_off && remain_q != CNT_W'(1))
      |=> $stable(dev_q)); // R9

  AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q == ST_MOVE && xfer_ack_i && !run_off && remain_q != CNT_W'(1))
      |=> (mem_q == $past(mem_q) + {29'd0, $past(wbytes)})); // R9

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rs_n)
    rd_req_o |-> (rd_addr_o[1:0] == 2'b00)); // R1

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    (state_q == ST_MOVE && !xfer_ack_i && !run_off) |=> (state_q == ST_MOVE)); // R7
endmodule

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        dir_to_dev_i, start_i;
  logic [31:0] reg_dev_i, reg_mem_i, reg_size_i, reg_link_i;
  logic        rd_req_o, rd_gnt_i, xfer_req_o, xfer_ack_i, done_o, err_o;
  logic [31:0] rd_addr_o, rd_data_i, xfer_src_o, xfer_dst_o;
  logic [2:0]  xfer_bytes_o;
  logic [1:0]  state_o;

  always #4 clk = ~clk;

  dma_chain_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_to_dev_i(dir_to_dev_i),
    .start_i(start_i), .reg_dev_i(reg_dev_i), .reg_mem_i(reg_mem_i),
    .reg_size_i(reg_size_i), .reg_link_i(reg_link_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
    .rd_data_i(rd_data_i), .xfer_req_o(xfer_req_o), .xfer_src_o(xfer_src_o),
    .xfer_dst_o(xfer_dst_o), .xfer_bytes_o(xfer_bytes_o),
    .xfer_ack_i(xfer_ack_i), .state_o(state_o), .done_o(done_o), .err_o(err_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit wd_hit   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  wc;
    logic [10:0] cnt;
    logic [1:0]  ctl;
    logic        dir;
    logic [1:0]  mode;
    logic [11:0] n;
    logic        d;
    logic        e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 11'd3,     2'd1, 1'b1, 2'd2, 12'd3,    1'b1, 1'b0},
    '{2'd3, 11'd5,     2'd0, 1'b0, 2'd2, 12'd5,    1'b0, 1'b0},
    '{2'd2, 11'd4,     2'd3, 1'b1, 2'd3, 12'd4,    1'b1, 1'b0},
    '{2'd2, 11'h3FF,   2'd1, 1'b0, 2'd1, 12'd1023, 1'b1, 1'b0},
    '{2'd3, 11'h400,   2'd1, 1'b1, 2'd2, 12'd0,    1'b1, 1'b1},
    '{2'd0, 11'h7FF,   2'd0, 1'b1, 2'd1, 12'd2047, 1'b0, 1'b0},
    '{2'd2, 11'h400,   2'd0, 1'b0, 2'd2, 12'd0,    1'b1, 1'b1},
    '{2'd1, 11'd2,     2'd1, 1'b0, 2'd2, 12'd0,    1'b1, 1'b1},
    '{2'd0, 11'd0,     2'd1, 1'b1, 2'd2, 12'd0,    1'b1, 1'b0}
  };

  // expected element addresses: linear mode or explicit list
  bit          lin_mode;
  logic [31:0] lin_mem, lin_dev;
  int          lin_wb;
  logic [31:0] lst_mem [8];
  logic [31:0] lst_dev [8];
  logic        cur_dir;

  function automatic int wbytes_of(input logic [1:0] wc);
    case (wc)
      2'd3: return 1;
      2'd2: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h200: return 32'h4000_0010;
      32'h204: return 32'h0000_2000;
      32'h208: return 32'h0000_3003;
      32'h20C: return 32'h0000_0302;
      32'h300: return 32'h4000_0020;
      32'h304: return 32'h0000_3000;
      32'h308: return 32'h0000_2000;
      32'h30C: return 32'h0000_0001;
      32'h400: return 32'h0;
      32'h404: return 32'h0;
      32'h408: return 32'h0000_1001;
      32'h40C: return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  int r_x, r_done, r_err, r_fetch, r_bad;

  task automatic run_job(input logic [1:0] mode, input logic dir,
                         input logic [31:0] dev, mem, size, link,
                         input int restart_at, input int abort_at);
    logic [31:0] es, ed, em, edv;
    r_x = 0; r_done = 0; r_err = 0; r_fetch = 0; r_bad = 0;
    cur_dir = dir;
    mode_i = mode; dir_to_dev_i = dir;
    reg_dev_i = dev; reg_mem_i = mem; reg_size_i = size; reg_link_i = link;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int it = 0; it < 5000; it++) begin
      if (done_o) r_done++;
      if (err_o)  r_err++;
      if (state_o == 2'd0) break;
      if (xfer_req_o) begin
        em  = lin_mode ? lin_mem + 32'(r_x * lin_wb) : lst_mem[r_x % 8];
        edv = lin_mode ? lin_dev : lst_dev[r_x % 8];
        es  = cur_dir ? em : edv;
        ed  = cur_dir ? edv : em;
        if (xfer_src_o !== es || xfer_dst_o !== ed) r_bad++;
        if (lin_mode && int'(xfer_bytes_o) != lin_wb) r_bad++;
        r_x++;
        xfer_ack_i = 1'b1;
      end else xfer_ack_i = 1'b0;
      if (rd_req_o) begin
        if (int'(rd_addr_o[3:2]) != (r_fetch % 4)) r_bad++;
        rd_data_i = mem_word(rd_addr_o);
        rd_gnt_i  = 1'b1;
        r_fetch++;
      end else rd_gnt_i = 1'b0;
      if (it == restart_at) begin
        start_i = 1'b1; reg_mem_i = 32'h0009_0000;
      end else start_i = 1'b0;
      if (it == abort_at) mode_i = 2'd0;
      @(negedge clk);
    end
    xfer_ack_i = 1'b0; rd_gnt_i = 1'b0; start_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd0; dir_to_dev_i = 1'b0; start_i = 1'b0;
    reg_dev_i = '0; reg_mem_i = '0; reg_size_i = '0; reg_link_i = '0;
    rd_gnt_i = 1'b0; rd_data_i = '0; xfer_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    chk(state_o == 2'd0, "R8 reset state", state_o, 0);
    chk(!done_o, "R8 reset done", done_o, 0);
    chk(!err_o, "R8 reset err", err_o, 0);
    chk(!xfer_req_o, "R8 reset xfer_req", xfer_req_o, 0);
    chk(!rd_req_o, "R8 reset rd_req", rd_req_o, 0);

    // table of single-descriptor jobs: R2 R3 R4 R5 R9 R10
    lin_mode = 1'b1;
    for (int v = 0; v < NV; v++) begin
      lin_mem = 32'h0001_0000 + 32'(v) * 32'h1000;
      lin_dev = 32'h6000_0000 + 32'(v) * 32'h10;
      lin_wb  = wbytes_of(VECS[v].wc);
      run_job(VECS[v].mode, VECS[v].dir, lin_dev, lin_mem,
              {18'd0, VECS[v].wc, 1'b0, VECS[v].cnt},
              32'h0000_0500 | {30'd0, VECS[v].ctl}, -1, -1);
      chk(r_x == int'(VECS[v].n), "R2/R3/R10 element count", r_x, VECS[v].n);
      chk(r_done == int'(VECS[v].d), "R4 completion pulses", r_done, VECS[v].d);
      chk(r_err == int'(VECS[v].e), "R3 error pulses", r_err, VECS[v].e);
      chk(r_fetch == 0, "R5 no descriptor reads", r_fetch, 0);
      chk(r_bad == 0, "R9 element addresses and width", r_bad, 0);
      @(negedge clk);
    end

    // R1 chained walk of three descriptors, last one empty (R10)
    lin_mode = 1'b0;
    lst_mem[0] = 32'h1000; lst_mem[1] = 32'h1004;
    lst_mem[2] = 32'h2000; lst_mem[3] = 32'h2001; lst_mem[4] = 32'h2002;
    lst_dev[0] = 32'h4000_0000; lst_dev[1] = 32'h4000_0000;
    lst_dev[2] = 32'h4000_0010; lst_dev[3] = 32'h4000_0010; lst_dev[4] = 32'h4000_0010;
    run_job(2'd1, 1'b1, 32'h4000_0000, 32'h1000, 32'h0000_0002, 32'h0000_0203, -1, -1);
    chk(r_fetch == 8, "R1 words fetched", r_fetch, 8);
    chk(r_x == 5, "R1 elements across chain", r_x, 5);
    chk(r_done == 2, "R4 follow-with-irq plus end pulses", r_done, 2);
    chk(r_err == 0, "R1 no error", r_err, 0);
    chk(r_bad == 0, "R1 fetch order and addresses", r_bad, 0);

    // R3 bad descriptor reached through a link
    lst_mem[0] = 32'h8000; lst_dev[0] = 32'h5000_0000;
    run_job(2'd1, 1'b0, 32'h5000_0000, 32'h8000, 32'h0000_3001, 32'h0000_0402, -1, -1);
    chk(r_fetch == 4, "R1 one descriptor fetched", r_fetch, 4);
    chk(r_x == 1, "R3 only the good element moved", r_x, 1);
    chk(r_err == 1 && r_done == 1, "R3 error with completion", r_err * 16 + r_done, 17);
    chk(r_bad == 0, "R9 device to memory addresses", r_bad, 0);

    // R7 start and new register values while busy are ignored
    lin_mode = 1'b1; lin_mem = 32'h7000; lin_dev = 32'h6100_0000; lin_wb = 4;
    run_job(2'd2, 1'b1, lin_dev, lin_mem, 32'h0000_0006, 32'h1, 3, -1);
    chk(r_x == 6, "R7 count unchanged by busy start", r_x, 6);
    chk(r_bad == 0, "R7 addresses unchanged by busy start", r_bad, 0);
    chk(r_done == 1, "R7 single completion", r_done, 1);

    // R6 abort mid-transfer
    lin_mem = 32'hA000; lin_dev = 32'h6200_0000; lin_wb = 4;
    run_job(2'd1, 1'b0, lin_dev, lin_mem, 32'h0000_0014, 32'h1, -1, 5);
    chk(r_x < 20 && r_x > 0, "R6 abort cut transfer short", r_x, 6);
    chk(r_done == 0 && r_err == 0, "R6 no events on abort", r_done + r_err, 0);
    @(negedge clk);
    chk(state_o == 2'd0 && !xfer_req_o, "R6 idle after abort", state_o, 0);

    // R7 start with mode disabled is ignored
    mode_i = 2'd0; reg_size_i = 32'h0000_0004; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(state_o == 2'd0, "R7 start ignored when disabled", state_o, 0);
    chk(!xfer_req_o && !done_o, "R7 no activity when disabled", xfer_req_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule